// File: doc/BRIEF.md
# Paged I2C Target Register Interface

This block is an I2C target that serves a small identity and control register space and a read-only nonvolatile store. The store holds eight pages of 128 bytes. A controller selects one page through a mode register, and that page then appears at register addresses 0x80 to 0xFF. The target decodes start, repeated start and stop conditions, its 7-bit device address, a register-address byte and any following data bytes. The register pointer advances by one after each data byte.

SCL and SDA are oversampled on the system clock, so no logic runs in the bus clock domain. The target drives SDA only through an open-drain enable, `sda_oe`. The store is a plain on-chip array that is filled through a preload port before bus traffic begins. Pad drivers and programming of the store are handled outside the block.

Top module: `paged_i2c_target`

## Requirements
- R1: The target acknowledges only the device address {4'b1010, strap_i} (0x50 to 0x57). After any other address it leaves SDA released for the ACK bit and for the rest of that transfer.
- R2: Register 0x00 reads 0x51 and register 0x01 reads 0x18.
- R3: Register 0x02 reads {2'b00, major-1 in bits 5:4, minor-1 in bits 3:1, 1'b0}.
- R4: Register 0x03 (bank) and register 0x04 (id) each carry a 7-bit value in bits 6:0, with bit 7 set so that the byte holds an odd number of ones.
- R5: Register 0x0B is the mode register. Bits 2:0 select the page and bit 3 is the addressing-mode flag; both are written by a data byte to 0x0B. Bits 7:4 always read zero.
- R6: A read at an address from 0x80 to 0xFF returns byte (page*128 + addr[6:0]) of the store.
- R7: While the selected page is nonzero, every register below 0x80 except 0x0B reads zero.
- R8: A repeated start keeps the register pointer. A start issued after a stop (a plain start) clears the pointer to 0x00.
- R9: The pointer increments after each data byte, both read and write. Above 0x7F it wraps from 0xFF to 0x80 and stays inside the current page.
- R10: A data byte written anywhere other than 0x0B is acknowledged and changes nothing. This covers the store window and the identity registers.
- R11: A stop condition releases SDA and returns the target to idle. When the controller NACKs a read byte, the target releases SDA and stops sending.
- R12: While reset is asserted and after it is released, `sda_oe` is low and the mode register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low three bits of the device address |
| pl_we | input | 1 | Store preload write enable |
| pl_addr | input | 10 | Store preload byte address |
| pl_data | input | 8 | Store preload data |

## Verification
The bench keeps the default geometry of eight pages of 128 bytes. This lets it reach both ends of a page window and a non-zero page (page 3). It sets the revision to 2.3, the bank value to 0x05 and the id value to 0x2C, so the revision layout can be checked and the parity bit comes out both set and clear. The strap is tied to 5, giving device address 0x55, so 0x50 and 0x57 are foreign addresses at either end of the strap range.

// File: rtl/pgi2c_pkg.sv
package pgi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX
  } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c,
  output logic sda_s
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_ff[1] & ~scl_d;
  assign scl_fall = ~scl_ff[1] & scl_d;
  assign start_c  = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_c   = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int          RA_W     = 8,
  parameter logic [6:0]  DEV_BASE = 7'h50
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_c,
  input  logic            stop_c,
  input  logic            sda_s,
  input  logic [2:0]      strap,
  input  logic [7:0]      rd_data,
  output logic            sda_oe,
  output logic [RA_W-1:0] ptr,
  output logic            wr_en,
  output logic [RA_W-1:0] wr_addr,
  output logic [7:0]      wr_data
);
  import pgi2c_pkg::*;

  eng_state_t state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, got_ptr, busy, nack_q, ptr_load;
  logic [6:0] my_addr;

  assign my_addr = {DEV_BASE[6:3], strap};

  function automatic logic [RA_W-1:0] step(input logic [RA_W-1:0] p);
    if (p[RA_W-1]) return {1'b1, p[RA_W-2:0] + 1'b1};
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; sda_oe <= 1'b0; cnt <= '0; sh <= '0;
      rw <= 1'b0; got_ptr <= 1'b0; busy <= 1'b0; nack_q <= 1'b1;
      ptr <= '0; ptr_load <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en    <= 1'b0;
      ptr_load <= 1'b0;
      if (stop_c) begin
        state <= ST_IDLE; sda_oe <= 1'b0; busy <= 1'b0;
      end else if (start_c) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; busy <= 1'b1;
        if (!busy) ptr <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  sda_oe <= 1'b1; rw <= sh[0]; got_ptr <= 1'b0;
                  state  <= ST_ACK_ADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK_RX;
                if (!got_ptr) begin
                  ptr <= sh[RA_W-1:0]; got_ptr <= 1'b1; ptr_load <= 1'b1;
                end else begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                  ptr   <= step(ptr);
                end
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh <= rd_data; sda_oe <= ~rd_data[7];
                ptr <= step(ptr); state <= ST_TX;
              end else begin
                sda_oe <= 1'b0; state <= ST_RX;
              end
            end
          end
          ST_ACK_RX: begin
            if (scl_fall) begin
              sda_oe <= 1'b0; state <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; cnt <= '0; state <= ST_ACK_TX;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_ACK_TX: begin
            if (scl_rise) nack_q <= sda_s;
            if (scl_fall) begin
              if (nack_q) begin
                state <= ST_IDLE;
              end else begin
                sh <= rd_data; sda_oe <= ~rd_data[7];
                ptr <= step(ptr); state <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a foreign address never gets an ACK
  p_nack_foreign_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && scl_fall && cnt == 4'd8 && sh[7:1] != my_addr
     && !start_c && !stop_c) |=> !sda_oe);

  // R11: stop always frees the line
  p_release_on_stop_r11: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);

  // R8: plain start clears the pointer
  p_plain_start_r8: assert property (@(posedge clk) disable iff (rst)
    (start_c && !stop_c && !busy) |=> (ptr == '0));

  // R9: inside the window the pointer only leaves by an explicit load
  p_window_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (ptr[RA_W-1] && !(start_c && !busy)) |=> (ptr[RA_W-1] || ptr_load));
endmodule

// File: rtl/i2c_reg_space.sv
module i2c_reg_space #(
  parameter int         NV_PAGES   = 8,
  parameter int         PAGE_BYTES = 128,
  parameter int         REV_MAJOR  = 1,
  parameter int         REV_MINOR  = 1,
  parameter logic [6:0] BANK7      = 7'h00,
  parameter logic [6:0] ID7        = 7'h01,
  parameter logic [7:0] MODE_ADDR  = 8'h0B,
  localparam int        PAGE_W     = $clog2(NV_PAGES),
  localparam int        OFS_W      = $clog2(PAGE_BYTES),
  localparam int        RA_W       = OFS_W + 1,
  localparam int        NV_DEPTH   = NV_PAGES * PAGE_BYTES,
  localparam int        NV_AW      = $clog2(NV_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RA_W-1:0]  ptr,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             pl_we,
  input  logic [NV_AW-1:0] pl_addr,
  input  logic [7:0]       pl_data,
  output logic [7:0]       rd_data
);
  localparam logic [1:0] MAJ_F = 2'(REV_MAJOR - 1);
  localparam logic [2:0] MIN_F = 3'(REV_MINOR - 1);
  localparam logic [7:0] REV_B  = {2'b00, MAJ_F, MIN_F, 1'b0};
  localparam logic [7:0] BANK_B = {~^BANK7, BANK7};
  localparam logic [7:0] ID_B   = {~^ID7, ID7};

  logic [PAGE_W:0]   mode_q;
  logic [PAGE_W-1:0] page;
  logic [7:0]        vol_c, vol_q, nv_q;
  logic              win_q;
  logic [7:0]        nv_mem [NV_DEPTH];

  assign page = mode_q[PAGE_W-1:0];

  always_comb begin
    case (ptr)
      RA_W'(8'h00): vol_c = 8'h51;
      RA_W'(8'h01): vol_c = 8'h18;
      RA_W'(8'h02): vol_c = REV_B;
      RA_W'(8'h03): vol_c = BANK_B;
      RA_W'(8'h04): vol_c = ID_B;
      RA_W'(MODE_ADDR): vol_c = 8'(mode_q);
      default: vol_c = 8'h00;
    endcase
    if (page != '0 && ptr != RA_W'(MODE_ADDR)) vol_c = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; vol_q <= '0; win_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == RA_W'(MODE_ADDR)) mode_q <= wr_data[PAGE_W:0];
      vol_q <= vol_c;
      win_q <= ptr[RA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (pl_we) nv_mem[pl_addr] <= pl_data;
    nv_q <= nv_mem[{page, ptr[OFS_W-1:0]}];
  end

  assign rd_data = win_q ? nv_q : vol_q;

  // R5: only a data byte aimed at the mode register changes it
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == RA_W'(MODE_ADDR)) |=> $stable(mode_q));
endmodule

// File: rtl/paged_i2c_target.sv
module paged_i2c_target #(
  parameter int         NV_PAGES   = 8,
  parameter int         PAGE_BYTES = 128,
  parameter int         REV_MAJOR  = 1,
  parameter int         REV_MINOR  = 1,
  parameter logic [6:0] BANK7      = 7'h00,
  parameter logic [6:0] ID7        = 7'h01,
  parameter logic [6:0] DEV_BASE   = 7'h50
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic [2:0] strap_i,
  input  logic pl_we,
  input  logic [$clog2(NV_PAGES*PAGE_BYTES)-1:0] pl_addr,
  input  logic [7:0] pl_data
);
  localparam int RA_W = $clog2(PAGE_BYTES) + 1;

  logic            scl_rise, scl_fall, start_c, stop_c, sda_s;
  logic [RA_W-1:0] ptr, wr_addr;
  logic            wr_en;
  logic [7:0]      wr_data, rd_data;

  i2c_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_s(sda_s)
  );

  i2c_byte_engine #(.RA_W(RA_W), .DEV_BASE(DEV_BASE)) u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_s(sda_s), .strap(strap_i),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  i2c_reg_space #(
    .NV_PAGES(NV_PAGES), .PAGE_BYTES(PAGE_BYTES),
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR),
    .BANK7(BANK7), .ID7(ID7)
  ) u_regs (
    .clk(clk), .rst(rst), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .rd_data(rd_data)
  );
endmodule

// File: tb/paged_i2c_target_test.sv
`timescale 1ns/1ps
module paged_i2c_target_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic pl_we = 1'b0;
  logic [9:0] pl_addr = '0;
  logic [7:0] pl_data = '0;

  int checks = 0, fails = 0;
  bit exp_valid = 0, exp_oe = 0, done = 0;
  string cur_req = "R12";

  byte unsigned nv_ref [1024];
  int mode_ref = 0, ptr_ref = 0;
  bit busy_ref = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  paged_i2c_target #(.REV_MAJOR(2), .REV_MINOR(3), .BANK7(7'h05), .ID7(7'h2C)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(3'd5), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  // reference comparison of the open-drain enable on every clock of a stable window
  always @(negedge clk) begin
    if (!rst && exp_valid) begin
      checks++;
      if (sda_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s sda_oe actual=%0b expected=%0b at %0t", cur_req, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_next(int p);
    if (p >= 128) return 128 + ((p + 1) & 127);
    return p + 1;
  endfunction

  function automatic int ref_rd(int p);
    if (p >= 128) return nv_ref[(mode_ref & 7) * 128 + (p & 127)];
    if ((mode_ref & 7) != 0 && p != 11) return 0;
    case (p)
      0: return 8'h51;
      1: return 8'h18;
      2: return 8'h14;
      3: return 8'h85;
      4: return 8'h2C;
      11: return mode_ref & 15;
      default: return 0;
    endcase
  endfunction

  task automatic bit_cycle(bit b, bit chk, bit e_oe);
    sda_m = b; tick(Q);
    scl_m = 1'b1; exp_oe = e_oe; exp_valid = chk;
    tick(2 * Q);
    exp_valid = 0; scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    if (!busy_ref) ptr_ref = 0;
    busy_ref = 1;
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
    busy_ref = 0;
  endtask

  task automatic wr_byte(logic [7:0] b, bit e_ack);
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1, 0);
    bit_cycle(1'b1, 1, e_ack);
  endtask

  task automatic rd_byte(logic [7:0] e, bit m_ack);
    for (int i = 7; i >= 0; i--) bit_cycle(1'b1, 1, ~e[i]);
    bit_cycle(~m_ack, 1, 0);
  endtask

  task automatic dev_addr(logic [6:0] a, bit rd);
    wr_byte({a, rd}, a == 7'h55);
  endtask

  task automatic set_ptr(int p);
    wr_byte(8'(p), 1); ptr_ref = p;
  endtask

  task automatic wr_data(int d);
    wr_byte(8'(d), 1);
    if (ptr_ref == 11) mode_ref = d & 15;
    ptr_ref = ref_next(ptr_ref);
  endtask

  task automatic rd_model(bit m_ack);
    rd_byte(8'(ref_rd(ptr_ref)), m_ack);
    ptr_ref = ref_next(ptr_ref);
  endtask

  task automatic read_at(int p, int n);
    do_start(); dev_addr(7'h55, 0); set_ptr(p);
    do_start(); dev_addr(7'h55, 1);
    for (int i = 0; i < n; i++) rd_model(i != n - 1);
    do_stop();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      nv_ref[i] = 8'((i * 37 + 11) & 255);
      pl_we = 1'b1; pl_addr = 10'(i); pl_data = nv_ref[i];
      tick(1);
      if (i == 8) check_eq("R12 sda_oe in reset", int'(sda_oe), 0);
    end
    pl_we = 1'b0;
    tick(2); rst = 1'b0; tick(4);
    check_eq("R12 sda_oe after reset", int'(sda_oe), 0);
    cur_req = "R12"; read_at(11, 1);                 // mode reads 0x00

    cur_req = "R1";                                    // foreign addresses stay unanswered
    do_start(); dev_addr(7'h50, 0); wr_byte(8'h00, 0); do_stop();
    do_start(); dev_addr(7'h57, 1); wr_byte(8'hFF, 0); do_stop();

    cur_req = "R3";                                    // repeated start keeps pointer (R8)
    do_start(); dev_addr(7'h55, 0); wr_byte(8'h02, 1);
    do_start(); dev_addr(7'h55, 1);
    rd_byte(8'h14, 1);
    cur_req = "R4"; rd_byte(8'h85, 1); rd_byte(8'h2C, 0); do_stop();

    cur_req = "R2"; read_at(0, 2);

    cur_req = "R8";                                    // plain start resets pointer
    do_start(); dev_addr(7'h55, 0); set_ptr(4); do_stop();
    do_start(); dev_addr(7'h55, 1); rd_byte(8'h51, 0); do_stop();

    cur_req = "R5";
    do_start(); dev_addr(7'h55, 0); set_ptr(11); wr_data(8'hF8); do_stop();
    read_at(11, 1);
    check_eq("R5 model mode", mode_ref, 8);
    do_start(); dev_addr(7'h55, 0); set_ptr(11); wr_data(8'h03); do_stop();
    do_start(); dev_addr(7'h55, 0); set_ptr(11);
    do_start(); dev_addr(7'h55, 1); rd_byte(8'h03, 0); do_stop();

    cur_req = "R7"; read_at(0, 5);
    cur_req = "R6"; read_at(8'h80, 3);
    check_eq("R6 model byte", ref_rd(8'h80), int'(nv_ref[384]));
    cur_req = "R9"; read_at(8'hFE, 4);
    check_eq("R9 model wrap", ref_next(8'hFF), 8'h80);

    cur_req = "R10";
    do_start(); dev_addr(7'h55, 0); set_ptr(8'h90); wr_data(8'hAA); wr_data(8'h55); do_stop();
    read_at(8'h90, 2);
    do_start(); dev_addr(7'h55, 0); set_ptr(11); wr_data(8'h00); do_stop();
    do_start(); dev_addr(7'h55, 0); set_ptr(1); wr_data(8'h00); do_stop();
    do_start(); dev_addr(7'h55, 0); set_ptr(1);
    do_start(); dev_addr(7'h55, 1); rd_byte(8'h18, 0); do_stop();

    cur_req = "R11";                                   // stop in the middle of a byte
    do_start(); dev_addr(7'h55, 0);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, 1, 0);
    do_stop();
    tick(4); check_eq("R11 released after stop", int'(sda_oe), 0);
    read_at(0, 1);
    tick(4); check_eq("R11 released after master NACK", int'(sda_oe), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule